// File: doc/BRIEF.md
# Multi-Lane Serial Flash Operation Engine

This block sits on the host side of a serial flash link and runs one memory operation at a time. An operation has up to four phases in a fixed order: a one-byte opcode, an address of zero to three bytes, a number of dummy bytes, and a data stream that goes either to the device or from it. Any phase except the opcode may be empty, and the engine then skips it. The address, dummy and data phases each have their own lane width (one, two or four IO lines). A single operation can therefore send its address on one line and move its data on four, or run address, dummy and data all on two lines.

The engine drives the serial clock and the active-low chip select. It drives the four IO lines through separate output, output-enable and input vectors, and the pad ring outside the block turns these into bidirectional pins. Write data enters and read data leaves through byte-wide valid/ready streams. When a stream is not ready at a byte boundary, the engine holds the serial clock low and waits.

The control state machine has six states:
- `ST_IDLE`: a request is accepted here; goes to `ST_CMD`.
- `ST_CMD`: sends the opcode.
- `ST_ADDR`, `ST_DUMMY`, `ST_DATA`: the optional phases.
- `ST_TAIL`: one low half-period with chip select still asserted; goes back to `ST_IDLE`.

At the end of each phase the engine moves to the next phase whose count is non-zero. If none is left, it goes to `ST_TAIL`.

Top module: `spi_op_engine`

## Requirements
- R1: A request is accepted on a clock where `req_valid` is high and `busy` is low. `busy` is high from the next clock until chip select has been released. `req_valid` has no effect while `busy` is high.
- R2: `sck` idles low. `cs_n` goes low in the clock after acceptance, one clock before the first `sck` rise. `cs_n` returns high one clock after the last `sck` fall. `sck` is high only while `cs_n` is low.
- R3: Each serial clock beat is one clock low followed by one clock high. `io_o` and `io_oe` change only while `sck` is low and stay stable while it is high.
- R4: The opcode is sent first as 8 beats on IO0 only (`io_oe` = 4'b0001), most significant bit first.
- R5: A phase whose count is zero is skipped. An operation with no address, no dummy and no data lasts exactly 8 beats.
- R6: With N address bytes (N = 0 to 3), the low N bytes of `req_addr` are sent, the most significant of them first.
- R7: Lane code 0 selects one lane, code 1 selects two lanes, and codes 2 and 3 select four lanes. A byte takes 8, 4 or 2 beats, most significant bits first. On one lane, output is on IO0 and input is on IO1. On two lanes, IO1 carries the higher bit of each pair. On four lanes, IO3 carries the highest bit of each nibble. `io_oe` is always one of 0, 4'b0001, 4'b0011 or 4'b1111.
- R8: The dummy phase lasts `req_dummy` bytes at its own lane width, with `io_oe` all zero.
- R9: In a read (`req_dir` = 0), `io_oe` is zero and input is sampled at each `sck` rise. Each assembled byte appears on `rx_data` with `rx_valid`. A byte that has not been taken is never overwritten: `sck` stays low instead.
- R10: In a write (`req_dir` = 1), `req_len` bytes are taken from the tx stream by valid/ready and shifted out most significant bit first. `sck` stays low while a byte is not available.
- R11: The address, dummy and data lane widths are independent within one operation. The opcode always uses one lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation |
| req_opcode | input | 8 | Opcode byte |
| req_addr | input | 8*ADDR_BYTES | Address, right-aligned |
| req_abytes | input | AB_W | Address byte count, 0 to ADDR_BYTES |
| req_alanes | input | 2 | Address lane code |
| req_dummy | input | DUMMY_W | Dummy byte count |
| req_dlanes | input | 2 | Dummy lane code |
| req_dir | input | 1 | Data direction, 1 = write, 0 = read |
| req_len | input | LEN_W | Data byte count |
| req_tlanes | input | 2 | Data lane code |
| busy | output | 1 | Operation in flight |
| tx_valid | input | 1 | Write byte available |
| tx_data | input | 8 | Write byte |
| tx_ready | output | 1 | Write byte taken this clock |
| rx_valid | output | 1 | Read byte available |
| rx_data | output | 8 | Read byte |
| rx_ready | input | 1 | Read byte consumed |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_o | output | 4 | IO output values |
| io_oe | output | 4 | IO output enables |
| io_i | input | 4 | IO input values |

## Verification
The assertions check the following on every clock:
- the serial clock's one-clock high pulse and its confinement to an asserted chip select;
- the stability of the IO outputs while the clock is high;
- the legal set of output-enable patterns;
- the rule that a pending read byte holds still;
- the acceptance timing.

Only the bench's scenarios can show that the bit stream is correct: the opcode and address order, the beat count of each phase at its own width, the skipping of empty phases, and the read and write bytes assembled across mixed lane widths while both streams stall.

// File: rtl/spi_op_pkg.sv
package spi_op_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_TAIL
    } op_state_e;

    // number of IO lanes selected by a lane code
    function automatic logic [2:0] lane_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // beats per byte minus one for a lane code
    function automatic logic [2:0] beats_m1(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd7;
            2'd1:    return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/spi_op_lane_mux.sv
module spi_op_lane_mux (
    input  logic [7:0] sh,
    input  logic [1:0] lanes,
    input  logic       drive,
    input  logic [3:0] io_i,
    output logic [3:0] io_o,
    output logic [3:0] io_oe,
    output logic [3:0] rx_bits
);
    logic [3:0] val;
    logic [3:0] mask;

    always_comb begin
        unique case (lanes)
            2'd0: begin
                val     = {3'b000, sh[7]};
                mask    = 4'b0001;
                rx_bits = {3'b000, io_i[1]};
            end
            2'd1: begin
                val     = {2'b00, sh[7:6]};
                mask    = 4'b0011;
                rx_bits = {2'b00, io_i[1:0]};
            end
            default: begin
                val     = sh[7:4];
                mask    = 4'b1111;
                rx_bits = io_i;
            end
        endcase
        io_oe = drive ? mask : 4'b0000;
        io_o  = drive ? val  : 4'b0000;
    end
endmodule

// File: rtl/spi_op_ctrl.sv
module spi_op_ctrl
    import spi_op_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DUMMY_W    = 3,
    parameter int LEN_W      = 12,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int AB_W      = $clog2(ADDR_BYTES + 1),
    localparam int CNT_W     = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        req_opcode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [AB_W-1:0]   req_abytes,
    input  logic [1:0]        req_alanes,
    input  logic [DUMMY_W-1:0] req_dummy,
    input  logic [1:0]        req_dlanes,
    input  logic              req_dir,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_tlanes,
    output logic              busy,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    input  logic              rx_ready,
    output logic              sck,
    output logic              cs_n,
    output logic [7:0]        sh,
    output logic [1:0]        lanes,
    output logic              drive,
    input  logic [3:0]        rx_bits
);
    op_state_e          state_q, state_n, follow, tgt;
    logic               sck_q, sck_n, cs_q, cs_n_n, armed_q, armed_n;
    logic [2:0]         beat_q, beat_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [7:0]         sh_q, sh_n, rxsh_q, rxsh_n, rxd_q, rxd_n;
    logic               rxv_q, rxv_n;
    logic [ADDR_W-1:0]  addr_q, addr_n;
    logic [1:0]         lanes_q, lanes_n, tl;
    logic [AB_W-1:0]    ab_q, ab_n;
    logic [DUMMY_W-1:0] dum_q, dum_n;
    logic               dir_q, dir_n;
    logic [LEN_W-1:0]   len_q, len_n;
    logic [1:0]         la_q, la_n, ld_q, ld_n, lt_q, lt_n;
    logic               tx_take, rx_free;
    logic [7:0]         rx_shift;

    // phase that follows the current one, skipping empty ones
    always_comb begin
        case (state_q)
            ST_CMD:   follow = (ab_q != '0)  ? ST_ADDR :
                               (dum_q != '0) ? ST_DUMMY :
                               (len_q != '0) ? ST_DATA : ST_TAIL;
            ST_ADDR:  follow = (dum_q != '0) ? ST_DUMMY :
                               (len_q != '0) ? ST_DATA : ST_TAIL;
            ST_DUMMY: follow = (len_q != '0) ? ST_DATA : ST_TAIL;
            default:  follow = ST_TAIL;
        endcase
        tgt = (cnt_q == '0) ? follow : state_q;
        case (tgt)
            ST_ADDR:  tl = la_q;
            ST_DUMMY: tl = ld_q;
            ST_DATA:  tl = lt_q;
            default:  tl = lanes_q;
        endcase
    end

    assign rx_free  = !rxv_q || rx_ready;
    assign rx_shift = (rxsh_q << lane_bits(lanes_q)) | {4'b0000, rx_bits};

    // next-state and datapath process
    always_comb begin
        state_n = state_q;  sck_n = sck_q;    cs_n_n = cs_q;
        armed_n = armed_q;  beat_n = beat_q;  cnt_n = cnt_q;
        sh_n = sh_q;        rxsh_n = rxsh_q;  rxd_n = rxd_q;
        addr_n = addr_q;    lanes_n = lanes_q;
        ab_n = ab_q; dum_n = dum_q; dir_n = dir_q; len_n = len_q;
        la_n = la_q; ld_n = ld_q; lt_n = lt_q;
        tx_take = 1'b0;
        rxv_n = rxv_q && !rx_ready;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_n = ST_CMD;
                    cs_n_n  = 1'b0;
                    sck_n   = 1'b0;
                    armed_n = 1'b1;
                    sh_n    = req_opcode;
                    lanes_n = 2'd0;
                    beat_n  = 3'd7;
                    cnt_n   = '0;
                    addr_n  = req_addr << (8 * (ADDR_BYTES - int'(req_abytes)));
                    ab_n = req_abytes; dum_n = req_dummy; dir_n = req_dir;
                    len_n = req_len; la_n = req_alanes; ld_n = req_dlanes;
                    lt_n = req_tlanes;
                end
            end
            ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA: begin
                if (!sck_q) begin
                    if (armed_q) begin
                        sck_n = 1'b1;
                        if (state_q == ST_DATA && !dir_q) begin
                            rxsh_n = rx_shift;
                            if (beat_q == 3'd0) begin
                                rxd_n = rx_shift;
                                rxv_n = 1'b1;
                            end
                        end
                    end else if (state_q == ST_DATA) begin
                        if (dir_q) begin
                            if (tx_valid) begin
                                tx_take = 1'b1;
                                sh_n    = tx_data;
                                armed_n = 1'b1;
                            end
                        end else if (rx_free) begin
                            armed_n = 1'b1;
                        end
                    end
                end else begin
                    sck_n = 1'b0;
                    if (beat_q != 3'd0) begin
                        beat_n = beat_q - 3'd1;
                        sh_n   = sh_q << lane_bits(lanes_q);
                    end else begin
                        state_n = tgt;
                        lanes_n = tl;
                        beat_n  = beats_m1(tl);
                        if (cnt_q != '0) begin
                            cnt_n = cnt_q - CNT_W'(1);
                        end else begin
                            case (tgt)
                                ST_ADDR:  cnt_n = CNT_W'(ab_q) - CNT_W'(1);
                                ST_DUMMY: cnt_n = CNT_W'(dum_q) - CNT_W'(1);
                                ST_DATA:  cnt_n = CNT_W'(len_q) - CNT_W'(1);
                                default:  cnt_n = '0;
                            endcase
                        end
                        case (tgt)
                            ST_ADDR: begin
                                sh_n    = addr_q[ADDR_W-1 -: 8];
                                addr_n  = addr_q << 8;
                                armed_n = 1'b1;
                            end
                            ST_DUMMY: begin
                                sh_n    = 8'h00;
                                armed_n = 1'b1;
                            end
                            ST_DATA: begin
                                if (dir_q) begin
                                    armed_n = tx_valid;
                                    if (tx_valid) begin
                                        tx_take = 1'b1;
                                        sh_n    = tx_data;
                                    end
                                end else begin
                                    armed_n = rx_free;
                                end
                            end
                            default: armed_n = 1'b0;
                        endcase
                    end
                end
            end
            ST_TAIL: begin
                cs_n_n  = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; sck_q <= 1'b0; cs_q <= 1'b1; armed_q <= 1'b0;
            beat_q <= '0; cnt_q <= '0; sh_q <= '0; rxsh_q <= '0; rxd_q <= '0;
            rxv_q <= 1'b0; addr_q <= '0; lanes_q <= '0;
            ab_q <= '0; dum_q <= '0; dir_q <= 1'b0; len_q <= '0;
            la_q <= '0; ld_q <= '0; lt_q <= '0;
        end else begin
            state_q <= state_n; sck_q <= sck_n; cs_q <= cs_n_n; armed_q <= armed_n;
            beat_q <= beat_n; cnt_q <= cnt_n; sh_q <= sh_n; rxsh_q <= rxsh_n;
            rxd_q <= rxd_n; rxv_q <= rxv_n; addr_q <= addr_n; lanes_q <= lanes_n;
            ab_q <= ab_n; dum_q <= dum_n; dir_q <= dir_n; len_q <= len_n;
            la_q <= la_n; ld_q <= ld_n; lt_q <= lt_n;
        end
    end

    // output process
    always_comb begin
        busy     = (state_q != ST_IDLE);
        tx_ready = tx_take;
        rx_valid = rxv_q;
        rx_data  = rxd_q;
        sck      = sck_q;
        cs_n     = cs_q;
        sh       = sh_q;
        lanes    = lanes_q;
        drive    = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                   (state_q == ST_DATA && dir_q);
    end
endmodule

// File: rtl/spi_op_engine.sv
module spi_op_engine #(
    parameter int ADDR_BYTES = 3,
    parameter int DUMMY_W    = 3,
    parameter int LEN_W      = 12,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int AB_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [7:0]         req_opcode,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [AB_W-1:0]    req_abytes,
    input  logic [1:0]         req_alanes,
    input  logic [DUMMY_W-1:0] req_dummy,
    input  logic [1:0]         req_dlanes,
    input  logic               req_dir,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [1:0]         req_tlanes,
    output logic               busy,
    input  logic               tx_valid,
    input  logic [7:0]         tx_data,
    output logic               tx_ready,
    output logic               rx_valid,
    output logic [7:0]         rx_data,
    input  logic               rx_ready,
    output logic               sck,
    output logic               cs_n,
    output logic [3:0]         io_o,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_i
);
    logic [7:0] sh;
    logic [1:0] lanes;
    logic       drive;
    logic [3:0] rx_bits;

    spi_op_ctrl #(
        .ADDR_BYTES(ADDR_BYTES), .DUMMY_W(DUMMY_W), .LEN_W(LEN_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_opcode(req_opcode), .req_addr(req_addr),
        .req_abytes(req_abytes), .req_alanes(req_alanes), .req_dummy(req_dummy),
        .req_dlanes(req_dlanes), .req_dir(req_dir), .req_len(req_len),
        .req_tlanes(req_tlanes), .busy(busy),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .sck(sck), .cs_n(cs_n), .sh(sh), .lanes(lanes), .drive(drive),
        .rx_bits(rx_bits)
    );

    spi_op_lane_mux i_mux (
        .sh(sh), .lanes(lanes), .drive(drive), .io_i(io_i),
        .io_o(io_o), .io_oe(io_oe), .rx_bits(rx_bits)
    );
endmodule

// File: rtl/spi_op_engine_chk.sv
module spi_op_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_ready,
    input logic       sck,
    input logic       cs_n,
    input logic [3:0] io_o,
    input logic [3:0] io_oe
);
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && !cs_n));

    assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));

    assert_sck_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    assert_high_one_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> !sck);

    assert_io_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> ($stable(io_o) && $stable(io_oe)));

    assert_oe_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    assert_tx_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);
endmodule

bind spi_op_engine spi_op_engine_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .sck(sck), .cs_n(cs_n),
    .io_o(io_o), .io_oe(io_oe)
);

// File: tb/test_spi_op_engine.sv
`timescale 1ns/1ps
module test_spi_op_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_opcode = '0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_abytes = '0, req_alanes = '0, req_dlanes = '0, req_tlanes = '0;
    logic [2:0]  req_dummy = '0;
    logic        req_dir = 1'b0;
    logic [11:0] req_len = '0;
    logic        busy, tx_ready, rx_valid, sck, cs_n;
    logic        tx_valid = 1'b0, rx_ready = 1'b0;
    logic [7:0]  tx_data = '0, rx_data;
    logic [3:0]  io_o, io_oe;
    logic [3:0]  io_i = '0;

    always #2 clk = ~clk;

    spi_op_engine i_spi_op_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_abytes(req_abytes), .req_alanes(req_alanes),
        .req_dummy(req_dummy), .req_dlanes(req_dlanes), .req_dir(req_dir),
        .req_len(req_len), .req_tlanes(req_tlanes), .busy(busy),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .sck(sck), .cs_n(cs_n), .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
    );

    int checks = 0, errors = 0, cyc = 0;
    int kidx = 0, nb = 0, tx_idx = 0, rx_cnt = 0, ne = 0;
    logic [3:0] rec_o [256], rec_oe [256], exp_o [256], exp_oe [256];
    logic [7:0] exp_rx [64];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [3:0] dev_nib(input int k);
        return 4'((k * 7 + 3) ^ (k / 3));
    endfunction

    function automatic logic [7:0] tx_pat(input int j);
        return 8'(j * 61 + 29);
    endfunction

    function automatic int lw(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    task automatic add_byte(input logic [7:0] b, input int w, input bit drv);
        for (int t = 0; t < 8 / w; t++) begin
            logic [3:0] m;
            m = 4'((1 << w) - 1);
            exp_o[ne]  = 4'(b >> (8 - w * (t + 1))) & m;
            exp_oe[ne] = drv ? m : 4'b0000;
            ne++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(posedge sck) begin
        if (nb < 256) begin
            rec_o[nb]  = io_o;
            rec_oe[nb] = io_oe;
        end
        nb++;
    end

    always @(negedge sck) begin
        kidx++;
        io_i = dev_nib(kidx);
    end

    always @(negedge clk) begin
        tx_valid = (cyc % 5) != 2;
        tx_data  = tx_pat(tx_idx);
        rx_ready = (cyc % 3) != 1;
        #1;
        if (tx_valid && tx_ready) tx_idx++;
        if (rx_valid && rx_ready) begin
            // R9: read byte assembled from sampled lanes
            chk(rx_cnt < 64 && rx_data == exp_rx[rx_cnt], "R9", "read byte",
                rx_data, exp_rx[rx_cnt]);
            rx_cnt++;
        end
    end

    task automatic run_txn(input logic [7:0] op, input int ab, input logic [23:0] addr,
                           input logic [1:0] la, input int dum, input logic [1:0] ld,
                           input bit dir, input int len, input logic [1:0] lt,
                           input bit poke);
        int b0, wt, beats_ok, first_bad, wait_c;
        @(negedge clk); #1.5;
        ne = 0;
        add_byte(op, 1, 1'b1);
        for (int i = ab - 1; i >= 0; i--) add_byte(8'(addr >> (8 * i)), lw(la), 1'b1);
        for (int i = 0; i < dum; i++) add_byte(8'h00, lw(ld), 1'b0);
        b0 = ne;
        wt = lw(lt);
        for (int j = 0; j < len; j++) add_byte(dir ? tx_pat(j) : 8'h00, wt, dir);
        for (int j = 0; j < len && j < 64; j++) begin
            logic [7:0] v;
            v = '0;
            for (int t = 0; t < 8 / wt; t++) begin
                logic [3:0] n;
                n = dev_nib(b0 + j * (8 / wt) + t);
                if (wt == 1) v = {v[6:0], n[1]};
                else if (wt == 2) v = {v[5:0], n[1:0]};
                else v = {v[3:0], n};
            end
            exp_rx[j] = v;
        end
        nb = 0; kidx = 0; io_i = dev_nib(0); tx_idx = 0; rx_cnt = 0;
        req_opcode = op; req_addr = addr; req_abytes = 2'(ab); req_alanes = la;
        req_dummy = 3'(dum); req_dlanes = ld; req_dir = dir; req_len = 12'(len);
        req_tlanes = lt; req_valid = 1'b1;
        @(negedge clk); #1.5;
        req_valid = 1'b0;
        chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
        chk(cs_n == 1'b0 && sck == 1'b0, "R2", "cs low before first sck rise",
            {cs_n, sck}, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            #1.5; req_opcode = 8'h5A; req_valid = 1'b1;
            @(negedge clk); #1.5; req_valid = 1'b0;
        end
        wait_c = 0;
        while (busy && wait_c < 2000) begin @(negedge clk); wait_c++; end
        repeat (6) @(negedge clk);
        #1.5;
        chk(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0, "R2", "released after op",
            {busy, cs_n, sck}, 2);
        beats_ok = (nb == ne);
        first_bad = -1;
        for (int k = 0; k < ne && k < 256; k++) begin
            if (beats_ok && first_bad < 0 &&
                (rec_oe[k] != exp_oe[k] || (rec_o[k] & exp_oe[k]) != (exp_o[k] & exp_oe[k])))
                first_bad = k;
        end
        // R4 R5 R6 R7 R8 R11: beat count and per-beat lanes
        chk(beats_ok != 0, "R5", "beat count", nb, ne);
        if (beats_ok)
            chk(first_bad < 0, "R11", "beat stream first mismatch index",
                first_bad, -1);
        if (dir) chk(tx_idx == len, "R10", "write bytes taken", tx_idx, len);
        else chk(rx_cnt == len, "R9", "read bytes delivered", rx_cnt, len);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0, "R1", "request during busy ignored", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sck && !busy && io_oe == 4'b0 && !rx_valid && !tx_ready,
            "R2", "reset state", {cs_n, sck, busy, io_oe}, 8);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R5: opcode-only operation
        run_txn(8'hFF, 0, 24'h0, 2'd0, 0, 2'd0, 1'b0, 0, 2'd0, 1'b0);
        chk(ne == 8, "R4", "opcode-only beats", nb, 8);
        // R8: dummy then empty data phase
        run_txn(8'h9F, 0, 24'h0, 2'd0, 2, 2'd2, 1'b0, 0, 2'd0, 1'b0);
        // R7: code 3 acts as four lanes
        run_txn(8'h6B, 2, 24'h00C3A5, 2'd3, 1, 2'd3, 1'b0, 2, 2'd3, 1'b0);
        // R1: request while busy
        run_txn(8'h0B, 3, 24'h123456, 2'd0, 1, 2'd0, 1'b0, 3, 2'd0, 1'b1);
        // R6 R10 R11: sweep of address size and lane mixes
        for (int ab = 0; ab < 4; ab++)
            for (int la = 0; la < 3; la++)
                for (int ld = 0; ld < 3; ld++)
                    for (int lt = 0; lt < 3; lt++)
                        for (int d = 0; d < 2; d++)
                            run_txn(8'(ab * 16 + la * 4 + ld + lt * 8 + d * 100), ab,
                                    24'hA5C3E1 ^ 24'(ab * 4099 + la * 77 + lt),
                                    2'(la), (ab + la + lt) % 3, 2'(ld), d[0],
                                    1 + (ld + lt + ab) % 3, 2'(lt), 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule